// File: doc/BRIEF.md
# Dual-Speed Gated Timer/Counter (13-bit mode)

This block is a 16-bit timer/counter held as a high byte and a low byte. A bus writes both bytes and reads them back. It runs in the 13-bit mode only. The high byte carries count bits 12..5. The low five bits of the low byte carry count bits 4..0, so the low byte works as a divide-by-32 stage in front of the high byte. The top three bits of the low byte keep whatever was last written to them and the count never touches them.

The source of each increment is one of two. It can be an internal machine-cycle tick from a prescaler that divides the clock by 12, or by 6 when the fast select is set. A chip-wide option input forces the divide-by-12 rate whatever the fast select says. The other source is a falling edge on an external count pin, taken through a two-stage synchronizer.

Counting happens only while the run bit is set, and then only if the gate bit is clear or the gate pin is high. When the count goes from 1FFFh to 0000h, an overflow flag is set. That flag raises an interrupt request if the interrupt enable is set. The flag is cleared by a software clear strobe or by an interrupt acknowledge.

The control register is written with `ctl_wr` from `bus_wdata`. Bit 0 is run, bit 1 is gate, bit 2 selects the external source, bit 3 selects the fast rate and bit 4 is the interrupt enable. All control bits reset to 0.

Top module: `gtc_timer13`

## Requirements
- R1: While reset is asserted and after it is released, both count bytes read 00h, the overflow flag and the interrupt request are 0, and every control bit (run, gate, source, fast, interrupt enable) is 0.
- R2: With control bit 3 (fast) at 0 and the internal source selected, the count advances once every 12 clocks.
- R3: With control bit 3 at 1 and `opt_slow` at 0, the internal count advances once every 6 clocks.
- R4: While `opt_slow` is 1, the internal rate is one per 12 clocks whatever control bit 3 says.
- R5: The count changes only when control bit 0 (run) is 1 and either control bit 1 (gate) is 0 or `gate_pin` is 1; otherwise both count bytes hold.
- R6: With control bit 2 at 1, each falling edge on `count_pin` advances the count exactly once, on the third rising clock edge after the pin is first sampled low; rising edges and steady levels do not count.
- R7: The count is 13 bits: `cnt_hi` holds bits 12..5 and `cnt_lo[4:0]` holds bits 4..0. `cnt_lo[7:5]` keeps its written value while counting.
- R8: An increment from 1FFFh gives 0000h and sets `ovf_flag` on the same edge.
- R9: `irq_req` is high exactly when `ovf_flag` is 1 and control bit 4 (interrupt enable) is 1.
- R10: `ovf_clr` or `irq_ack` clears `ovf_flag` on the next edge. A wrap on that same edge leaves the flag set.
- R11: A write to either count byte takes that byte from `bus_wdata` and stops any increment of both bytes on that edge.
- R12: The prescaler phase is held at zero while run is 0, so the first internal increment after run is set comes a full 12 clocks (or 6 clocks) later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_wdata | input | 8 | Write data for the count bytes and the control register |
| hi_wr | input | 1 | Write strobe for the high count byte |
| lo_wr | input | 1 | Write strobe for the low count byte |
| ctl_wr | input | 1 | Write strobe for the control register (bits 4..0) |
| opt_slow | input | 1 | Chip option: forces the divide-by-12 rate |
| gate_pin | input | 1 | External gate level, already synchronous to clk |
| count_pin | input | 1 | External count input, asynchronous |
| ovf_clr | input | 1 | Software clear of the overflow flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the overflow flag |
| cnt_hi | output | 8 | High count byte |
| cnt_lo | output | 8 | Low count byte |
| ovf_flag | output | 1 | Overflow flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The timing rules are these:
- Writes to the count bytes and the control register appear one edge after their strobe.
- An internal increment lands on the 12th (or 6th) edge after run is seen set.
- A falling edge on the count pin lands on the third edge after the pin is first sampled low.
- The flag moves on the same edge as the wrap, and the request follows the flag with no delay.

A behavioural model in the bench advances by the same rules on each rising edge. The bench drives every input just after a falling edge and compares every output with the model at the next falling edge. Because of this, a result that comes one cycle early or late shows up as a miscompare.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  localparam int CTL_W = 5;

  // Control register, bit 0 first: run, gate, ext_src, fast, irq_en
  typedef struct packed {
    logic irq_en;
    logic fast;
    logic ext_src;
    logic gate;
    logic run;
  } gtc_ctl_t;
endpackage

// File: rtl/gtc_prescale.sv
module gtc_prescale #(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  input  logic force_slow,
  output logic tick
);
  localparam int PW = $clog2(SLOW_DIV);

  logic [PW-1:0] ph_q, ph_d, last_ph;

  always_comb begin
    last_ph = (fast && !force_slow) ? PW'(FAST_DIV - 1) : PW'(SLOW_DIV - 1);
    tick    = run && (ph_q >= last_ph);
    if (!run)      ph_d = '0;
    else if (tick) ph_d = '0;
    else           ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  // R12: phase starts from zero on the first cycle run is seen set
  assert_start_phase_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run)) |-> (ph_q == '0));
endmodule

// File: rtl/gtc_edge_sync.sv
module gtc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], pin};
    fall = sh_q[STAGES] && !sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // R6: one pulse per detected edge
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/gtc_count13.sv
module gtc_count13 #(
  parameter int DW      = 8,
  parameter int LO_BITS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [DW-1:0] wdata,
  input  logic          inc,
  output logic [DW-1:0] hi,
  output logic [DW-1:0] lo,
  output logic          wrap
);
  localparam int CW = DW + LO_BITS;

  logic [DW-1:0] hi_q, hi_d, lo_q, lo_d;
  logic [CW-1:0] cnt, cnt_inc;
  logic          wr_any;

  always_comb begin
    wr_any  = wr_hi || wr_lo;
    cnt     = {hi_q, lo_q[LO_BITS-1:0]};
    cnt_inc = cnt + 1'b1;
    wrap    = inc && !wr_any && (&cnt);
    hi_d    = hi_q;
    lo_d    = lo_q;
    if (wr_any) begin
      if (wr_hi) hi_d = wdata;
      if (wr_lo) lo_d = wdata;
    end else if (inc) begin
      hi_d               = cnt_inc[CW-1:LO_BITS];
      lo_d[LO_BITS-1:0]  = cnt_inc[LO_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

  // R11: write wins over increment
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (hi_q == $past(wdata)));
  // R8: the all-ones count rolls to zero
  assert_roll_to_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_any && (&cnt)) |=> (cnt == '0));

  generate
    if (LO_BITS < DW) begin : g_spare
      // R7: spare low-byte bits untouched by counting
      assert_spare_bits_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> $stable(lo_q[DW-1:LO_BITS]));
    end
  endgenerate
endmodule

// File: rtl/gtc_timer13.sv
module gtc_timer13 #(
  parameter int DW          = 8,
  parameter int LO_BITS     = 5,
  parameter int SLOW_DIV    = 12,
  parameter int FAST_DIV    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_wdata,
  input  logic          hi_wr,
  input  logic          lo_wr,
  input  logic          ctl_wr,
  input  logic          opt_slow,
  input  logic          gate_pin,
  input  logic          count_pin,
  input  logic          ovf_clr,
  input  logic          irq_ack,
  output logic [DW-1:0] cnt_hi,
  output logic [DW-1:0] cnt_lo,
  output logic          ovf_flag,
  output logic          irq_req
);
  import gtc_pkg::*;

  gtc_ctl_t ctl_q, ctl_d;
  logic     flag_q, flag_d;
  logic     tick, fall, cnt_en, wrap, gate_ok;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) ctl_d = gtc_ctl_t'(bus_wdata[CTL_W-1:0]);
    gate_ok = !ctl_q.gate || gate_pin;
    cnt_en  = ctl_q.run && gate_ok && (ctl_q.ext_src ? fall : tick);
    flag_d  = flag_q;
    if (wrap)                    flag_d = 1'b1;
    else if (ovf_clr || irq_ack) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      flag_q <= flag_d;
    end
  end

  gtc_prescale #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(ctl_q.run), .fast(ctl_q.fast),
    .force_slow(opt_slow), .tick(tick));

  gtc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(count_pin), .fall(fall));

  gtc_count13 #(.DW(DW), .LO_BITS(LO_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_hi(hi_wr), .wr_lo(lo_wr), .wdata(bus_wdata),
    .inc(cnt_en), .hi(cnt_hi), .lo(cnt_lo), .wrap(wrap));

  assign ovf_flag = flag_q;
  assign irq_req  = flag_q && ctl_q.irq_en;

  // R5: no enable and no write means the count holds
  assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !hi_wr && !lo_wr) |=> $stable({cnt_hi, cnt_lo}));
  // R8 / R10: a wrap always leaves the flag set
  assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);
  // R10: clear or acknowledge without a wrap drops the flag
  assert_clear_drops_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_clr || irq_ack) && !wrap) |=> !ovf_flag);
endmodule

// File: tb/gtc_timer13_tb.sv
module gtc_timer13_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_wdata;
  logic       hi_wr, lo_wr, ctl_wr, opt_slow, gate_pin, count_pin, ovf_clr, irq_ack;
  logic [7:0] cnt_hi, cnt_lo;
  logic       ovf_flag, irq_req;

  always #10 clk = ~clk;

  gtc_timer13 u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .hi_wr(hi_wr), .lo_wr(lo_wr),
    .ctl_wr(ctl_wr), .opt_slow(opt_slow), .gate_pin(gate_pin), .count_pin(count_pin),
    .ovf_clr(ovf_clr), .irq_ack(irq_ack), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo),
    .ovf_flag(ovf_flag), .irq_req(irq_req));

  int    n_vec = 0;
  int    n_bad = 0;
  string phase = "R1";
  bit    done  = 0;

  // reference state
  logic [7:0] m_hi, m_lo;
  logic [4:0] m_ctl;
  logic       m_flag;
  int         m_ph;
  logic [2:0] m_s;

  task automatic compare();
    logic exp_irq;
    exp_irq = m_flag && m_ctl[4];
    n_vec++;
    if (cnt_hi !== m_hi || cnt_lo !== m_lo || ovf_flag !== m_flag || irq_req !== exp_irq) begin
      n_bad++;
      $display("FAIL %s t=%0t hi/lo/flag/irq act %h/%h/%b/%b exp %h/%h/%b/%b",
               phase, $time, cnt_hi, cnt_lo, ovf_flag, irq_req, m_hi, m_lo, m_flag, exp_irq);
    end
  endtask

  // drive one cycle, advance the model by one rising edge, compare at the falling edge
  task automatic step(input logic whi, input logic wlo, input logic wctl,
                      input logic [7:0] wd, input logic clr, input logic ack);
    int div; bit tick, fall, en, ovf; int v;
    hi_wr = whi; lo_wr = wlo; ctl_wr = wctl; bus_wdata = wd; ovf_clr = clr; irq_ack = ack;
    div  = (m_ctl[3] && !opt_slow) ? 6 : 12;
    tick = m_ctl[0] && (m_ph >= div - 1);
    fall = m_s[2] && !m_s[1];
    en   = m_ctl[0] && (!m_ctl[1] || gate_pin) && (m_ctl[2] ? fall : tick);
    m_ph = (!m_ctl[0] || tick) ? 0 : m_ph + 1;
    m_s  = {m_s[1:0], count_pin};
    ovf  = 0;
    if (whi || wlo) begin
      if (whi) m_hi = wd;
      if (wlo) m_lo = wd;
    end else if (en) begin
      v = int'(m_hi) * 32 + int'(m_lo & 8'h1f);
      if (v == 8191) ovf = 1;
      v = (v + 1) % 8192;
      m_hi = 8'(v / 32);
      m_lo = (m_lo & 8'he0) | 8'(v % 32);
    end
    if (ovf) m_flag = 1'b1;
    else if (clr || ack) m_flag = 1'b0;
    if (wctl) m_ctl = wd[4:0];
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, 0, 0);
  endtask

  task automatic set_ctl(input logic [7:0] c);
    step(0, 0, 1, c, 0, 0);
  endtask

  task automatic load(input logic [7:0] h, input logic [7:0] l);
    step(1, 0, 0, h, 0, 0);
    step(0, 1, 0, l, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_wdata = 0; hi_wr = 0; lo_wr = 0; ctl_wr = 0; opt_slow = 0;
    gate_pin = 0; count_pin = 1; ovf_clr = 0; irq_ack = 0;
    m_hi = 0; m_lo = 0; m_ctl = 0; m_flag = 0; m_ph = 0; m_s = 0;
    // R1: reset values, held and after release
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1;
    idle(5);

    phase = "R2"; set_ctl(8'h01); idle(60);
    phase = "R7"; load(8'h12, 8'hE3); idle(40);
    phase = "R3"; set_ctl(8'h09); idle(40);
    phase = "R4"; opt_slow = 1; idle(40); opt_slow = 0; idle(20);

    phase = "R12"; set_ctl(8'h08); idle(10); set_ctl(8'h01); idle(5);
    set_ctl(8'h00); idle(3); set_ctl(8'h01); idle(30);

    phase = "R5"; set_ctl(8'h03);
    for (int i = 0; i < 80; i++) begin gate_pin = ((i / 7) % 2) == 1; idle(1); end
    gate_pin = 0; set_ctl(8'h0A); idle(20);

    phase = "R6"; set_ctl(8'h05);
    for (int i = 0; i < 20; i++) begin
      count_pin = 0; idle((i % 3) + 1);
      count_pin = 1; idle((i % 4) + 1);
    end
    idle(6);

    phase = "R8"; set_ctl(8'h09); load(8'hFF, 8'hFC); idle(40);
    phase = "R9"; set_ctl(8'h19); idle(4);
    phase = "R10"; step(0, 0, 0, 8'h00, 1, 0); idle(2);
    load(8'hFF, 8'hFE);
    for (int i = 0; i < 30; i++) step(0, 0, 0, 8'h00, 0, 1);
    step(0, 0, 0, 8'h00, 0, 1); idle(3);

    phase = "R11"; load(8'hFF, 8'h1F);
    for (int i = 0; i < 20; i++) step(0, 1, 0, 8'h1F, 0, 0);
    for (int i = 0; i < 20; i++) step(1, 0, 0, 8'h7F, 0, 0);
    idle(30);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule